// File: doc/BRIEF.md
# Memory-to-Memory Copy Engine

This engine moves a block of bytes from one memory region to another through a single AXI4 master port. Its configuration arrives on plain pins: a one-cycle start strobe, a one-cycle stop strobe, a 3-bit beat size code, an 8-bit burst length code, a 32-bit byte count and separate 32-bit source and destination base addresses. On start it captures all of these, then repeats one burst at a time: a read burst fills an internal beat buffer, and a write burst of the same shape drains it to the destination. When the count is used up, or a stop has been seen, it raises a one-cycle done pulse and returns to idle.

All five AXI channels follow the usual valid/ready rules. On AR, AW and W the engine raises valid and keeps it, with the payload unchanged, until the slave takes it. The slave may stall any of these channels for as long as it likes. On R and B the engine is the receiver: it holds ready high for the whole read phase or response phase, so it never stalls the slave. The buffer holds a full 256-beat burst, so a read burst always completes without back-pressure from the engine. The byte count must be a whole number of bursts, and the size code must not exceed the width of the data bus.

Top module: `mm_copy_engine`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `ar_valid`, `r_ready`, `aw_valid`, `w_valid`, `b_ready` and `done_o` are all low.
- R2: A start strobe seen while idle with a nonzero count captures the configuration. The first AR request carries the source base address, `ar_len` equal to the length code, `ar_size` equal to the size code and `ar_burst` equal to 2'b01 (incrementing).
- R3: Each burst runs strictly in this order: AR handshake, R beats up to and including the one with `r_last`, AW handshake, W beats, B handshake. `ar_valid` is never high together with `aw_valid` or `w_valid`.
- R4: With B = (length code + 1) << size code bytes per burst, burst k reads from source + k*B and writes to destination + k*B. A full transfer issues exactly count/B bursts.
- R5: The W beats of a burst carry the R data of the same burst in the same order. `w_strb` is all ones, and `w_last` is high only on beat number length code + 1. After the transfer the destination region equals the source region.
- R6: `done_o` is high for exactly one cycle: the cycle after the final B handshake.
- R7: A start with a byte count of zero issues no AR request and raises `done_o` in the cycle after the start strobe.
- R8: A start strobe seen while a transfer is in progress is ignored. Addresses, burst count and the single done pulse are unchanged.
- R9: A stop strobe during a transfer lets the current burst finish through its B handshake. After that no further AR is issued and `done_o` pulses once.
- R10: While `ar_valid`, `aw_valid` or `w_valid` is high and the matching ready is low, that valid stays high in the next cycle and its address or data stays stable.
- R11: A length code of 255 (256 beats) is buffered completely and copied correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle start strobe |
| stop_i | input | 1 | One-cycle stop strobe |
| size_i | input | 3 | Beat size code used for ARSIZE/AWSIZE |
| len_i | input | 8 | Burst length code; each burst has len_i+1 beats |
| nbytes_i | input | 32 | Total bytes to copy |
| src_i | input | 32 | Source base address |
| dst_i | input | 32 | Destination base address |
| done_o | output | 1 | One-cycle completion pulse |
| ar_addr | output | 32 | Read address |
| ar_len | output | 8 | Read burst length |
| ar_size | output | 3 | Read beat size |
| ar_burst | output | 2 | Read burst type (incrementing) |
| ar_valid | output | 1 | Read address valid |
| ar_ready | input | 1 | Read address ready |
| r_data | input | 32 | Read data |
| r_last | input | 1 | Last read beat |
| r_valid | input | 1 | Read data valid |
| r_ready | output | 1 | Read data ready |
| aw_addr | output | 32 | Write address |
| aw_len | output | 8 | Write burst length |
| aw_size | output | 3 | Write beat size |
| aw_burst | output | 2 | Write burst type (incrementing) |
| aw_valid | output | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| w_data | output | 32 | Write data |
| w_strb | output | 4 | Write strobes, all ones |
| w_last | output | 1 | Last write beat |
| w_valid | output | 1 | Write data valid |
| w_ready | input | 1 | Write data ready |
| b_valid | input | 1 | Write response valid |
| b_ready | output | 1 | Write response ready |

## Verification
Each registered result has a fixed distance from the event that causes it. `done_o` appears in the cycle after the clock edge that completes the last B handshake, or the cycle after the start strobe when the count is zero. An AR appears one cycle after a start or after the previous burst's B handshake. AW appears one cycle after the R beat that carries `r_last`. The bench drives on the falling edge and predicts each handshake from the values it sees there, one nanosecond later. It records the cycle index of every handshake and of each done cycle, so done timing is compared as exact cycle differences. Address and data are compared at the handshake in which they are accepted, against queues built in advance from the requirements. Ready signals toggle pseudo-randomly, so the rules for holding valid under back-pressure are exercised throughout.

// File: rtl/cdma_pkg.sv
package cdma_pkg;
  typedef enum logic [2:0] {
    CP_IDLE, CP_AR, CP_RD, CP_AW, CP_WR, CP_BR, CP_FIN
  } cp_state_t;

  localparam logic [1:0] BURST_INCR = 2'b01;
endpackage

// File: rtl/cdma_beat_buf.sv
// Beat store: one write port fed by R, asynchronous read port feeding W.
module cdma_beat_buf #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/cdma_ptrs.sv
// Captured configuration plus the moving source/destination/remaining state.
module cdma_ptrs #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32,
  parameter int LEN_W  = 8,
  parameter int SIZE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [ADDR_W-1:0] src_q,
  output logic [ADDR_W-1:0] dst_q,
  output logic [SIZE_W-1:0] size_q,
  output logic [LEN_W-1:0]  len_q,
  output logic              last_burst
);
  logic [CNT_W-1:0] rem_q;
  logic [CNT_W-1:0] burst_bytes;

  assign burst_bytes = (CNT_W'(len_q) + 1'b1) << size_q;
  assign last_burst  = rem_q <= burst_bytes;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      rem_q  <= '0;
      size_q <= '0;
      len_q  <= '0;
    end else if (load) begin
      src_q  <= src_i;
      dst_q  <= dst_i;
      rem_q  <= cnt_i;
      size_q <= size_i;
      len_q  <= len_i;
    end else if (step) begin
      src_q <= src_q + ADDR_W'(burst_bytes);
      dst_q <= dst_q + ADDR_W'(burst_bytes);
      rem_q <= rem_q - burst_bytes;
    end
  end

  // A burst is only retired while at least a whole burst remains.
  assert_rem_covers_burst_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> rem_q >= burst_bytes);
endmodule

// File: rtl/cdma_seq.sv
// One-burst-at-a-time sequencer: AR -> R beats -> AW -> W beats -> B.
module cdma_seq import cdma_pkg::*; #(
  parameter int LEN_W = 8,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             cnt_zero,
  input  logic             last_burst,
  input  logic [LEN_W-1:0] len_q,
  output logic             ar_valid,
  input  logic             ar_ready,
  input  logic             r_valid,
  input  logic             r_last,
  output logic             r_ready,
  output logic             aw_valid,
  input  logic             aw_ready,
  output logic             w_valid,
  input  logic             w_ready,
  output logic             w_last,
  input  logic             b_valid,
  output logic             b_ready,
  output logic             load,
  output logic             step,
  output logic             done,
  output logic             buf_we,
  output logic [IDX_W-1:0] buf_widx,
  output logic [IDX_W-1:0] buf_ridx
);
  cp_state_t        st;
  logic [LEN_W-1:0] rd_beat, wr_beat;
  logic             stop_pend;

  always_comb begin
    ar_valid = (st == CP_AR);
    r_ready  = (st == CP_RD);
    aw_valid = (st == CP_AW);
    w_valid  = (st == CP_WR);
    b_ready  = (st == CP_BR);
    done     = (st == CP_FIN);
    w_last   = w_valid && (wr_beat == len_q);
    load     = (st == CP_IDLE) && start_i;
    step     = b_ready && b_valid;
    buf_we   = r_ready && r_valid;
    buf_widx = IDX_W'(rd_beat);
    buf_ridx = IDX_W'(wr_beat);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= CP_IDLE;
      rd_beat   <= '0;
      wr_beat   <= '0;
      stop_pend <= 1'b0;
    end else begin
      case (st)
        CP_IDLE: begin
          stop_pend <= 1'b0;
          if (start_i) st <= cnt_zero ? CP_FIN : CP_AR;
        end
        CP_AR: begin
          rd_beat <= '0;
          if (ar_ready) st <= CP_RD;
        end
        CP_RD: begin
          if (r_valid) begin
            rd_beat <= rd_beat + 1'b1;
            if (r_last) st <= CP_AW;
          end
        end
        CP_AW: begin
          wr_beat <= '0;
          if (aw_ready) st <= CP_WR;
        end
        CP_WR: begin
          if (w_ready) begin
            wr_beat <= wr_beat + 1'b1;
            if (w_last) st <= CP_BR;
          end
        end
        CP_BR: begin
          if (b_valid) st <= (last_burst || stop_pend || stop_i) ? CP_FIN : CP_AR;
        end
        CP_FIN:  st <= CP_IDLE;
        default: st <= CP_IDLE;
      endcase
      if (stop_i && st != CP_IDLE && st != CP_FIN) stop_pend <= 1'b1;
    end
  end

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_after_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
    step && last_burst |=> done);
  assert_ar_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ar_valid && !ar_ready |=> ar_valid);
  assert_w_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    w_valid && !w_ready |=> w_valid && $stable(buf_ridx));
  assert_wlast_to_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
    w_valid && w_ready && w_last |=> b_ready && !ar_valid);
endmodule

// File: rtl/mm_copy_engine.sv
module mm_copy_engine import cdma_pkg::*; #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 32,
  parameter int LEN_W     = 8,
  parameter int SIZE_W    = 3,
  parameter int BUF_DEPTH = 256,
  localparam int STRB_W   = DATA_W / 8,
  localparam int IDX_W    = $clog2(BUF_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [CNT_W-1:0]  nbytes_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] dst_i,
  output logic              done_o,
  output logic [ADDR_W-1:0] ar_addr,
  output logic [LEN_W-1:0]  ar_len,
  output logic [SIZE_W-1:0] ar_size,
  output logic [1:0]        ar_burst,
  output logic              ar_valid,
  input  logic              ar_ready,
  input  logic [DATA_W-1:0] r_data,
  input  logic              r_last,
  input  logic              r_valid,
  output logic              r_ready,
  output logic [ADDR_W-1:0] aw_addr,
  output logic [LEN_W-1:0]  aw_len,
  output logic [SIZE_W-1:0] aw_size,
  output logic [1:0]        aw_burst,
  output logic              aw_valid,
  input  logic              aw_ready,
  output logic [DATA_W-1:0] w_data,
  output logic [STRB_W-1:0] w_strb,
  output logic              w_last,
  output logic              w_valid,
  input  logic              w_ready,
  input  logic              b_valid,
  output logic              b_ready
);
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [SIZE_W-1:0] size_q;
  logic [LEN_W-1:0]  len_q;
  logic              last_burst, load, step;
  logic              buf_we;
  logic [IDX_W-1:0]  buf_widx, buf_ridx;

  cdma_ptrs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .src_i(src_i), .dst_i(dst_i), .cnt_i(nbytes_i), .size_i(size_i), .len_i(len_i),
    .src_q(src_q), .dst_q(dst_q), .size_q(size_q), .len_q(len_q),
    .last_burst(last_burst));

  cdma_seq #(.LEN_W(LEN_W), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .cnt_zero(nbytes_i == '0), .last_burst(last_burst), .len_q(len_q),
    .ar_valid(ar_valid), .ar_ready(ar_ready),
    .r_valid(r_valid), .r_last(r_last), .r_ready(r_ready),
    .aw_valid(aw_valid), .aw_ready(aw_ready),
    .w_valid(w_valid), .w_ready(w_ready), .w_last(w_last),
    .b_valid(b_valid), .b_ready(b_ready),
    .load(load), .step(step), .done(done_o),
    .buf_we(buf_we), .buf_widx(buf_widx), .buf_ridx(buf_ridx));

  cdma_beat_buf #(.DATA_W(DATA_W), .DEPTH(BUF_DEPTH)) u_buf (
    .clk(clk), .wr_en(buf_we), .wr_idx(buf_widx), .wr_data(r_data),
    .rd_idx(buf_ridx), .rd_data(w_data));

  assign ar_addr  = src_q;
  assign ar_len   = len_q;
  assign ar_size  = size_q;
  assign ar_burst = BURST_INCR;
  assign aw_addr  = dst_q;
  assign aw_len   = len_q;
  assign aw_size  = size_q;
  assign aw_burst = BURST_INCR;
  assign w_strb   = '1;

  assert_ar_addr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ar_valid && !ar_ready |=> $stable(ar_addr));
  assert_aw_addr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    aw_valid && !aw_ready |=> aw_valid && $stable(aw_addr));
  assert_no_read_write_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ar_valid |-> !aw_valid && !w_valid);
endmodule

// File: tb/mm_copy_engine_test.sv
module mm_copy_engine_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        start_i = 0, stop_i = 0;
  logic [2:0]  size_i = 0;
  logic [7:0]  len_i = 0;
  logic [31:0] nbytes_i = 0, src_i = 0, dst_i = 0;
  logic        done_o;
  logic [31:0] ar_addr, aw_addr, r_data = 0, w_data;
  logic [7:0]  ar_len, aw_len;
  logic [2:0]  ar_size, aw_size;
  logic [1:0]  ar_burst, aw_burst;
  logic        ar_valid, ar_ready = 0, r_last = 0, r_valid = 0, r_ready;
  logic        aw_valid, aw_ready = 0, w_last, w_valid, w_ready = 0, b_valid = 0, b_ready;
  logic [3:0]  w_strb;

  mm_copy_engine uut (.*);

  logic [31:0] mem [4096];
  logic [31:0] exp_ar[$], exp_aw[$], sb_data[$];
  int checks = 0, errors = 0, cyc = 0;
  int done_cnt = 0, done_cyc = 0, last_b_cyc = 0, ar_cnt = 0;
  logic [2:0] cur_size = 0;
  logic [7:0] cur_len = 0;
  bit stop_mode = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // Behavioural AXI slave and monitor: drives on falling edge, predicts handshakes.
  initial begin
    logic [15:0] lfsr = 16'hACE1;
    bit ar_hs = 0, r_hs = 0, aw_hs = 0, w_hs = 0, b_hs = 0;
    bit rd_active = 0, b_pend = 0, w_was_last = 0, r_was_last = 0;
    logic [31:0] rd_addr = 0, wr_addr = 0, a;
    logic [7:0]  rd_len = 0, rd_beat = 0, wr_beat = 0;
    logic [31:0] expd;
    forever begin
      @(negedge clk);
      cyc++;
      if (!rst_n) continue;
      if (ar_hs) begin rd_active = 1; rd_beat = 0; end
      if (r_hs) begin if (r_was_last) rd_active = 0; else rd_beat++; end
      if (w_hs && w_was_last) b_pend = 1;
      if (b_hs) b_pend = 0;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ar_ready = lfsr[0];
      aw_ready = lfsr[1];
      w_ready  = lfsr[2] | lfsr[3];
      r_valid  = rd_active && (lfsr[4] | lfsr[5]);
      a = rd_addr + (32'(rd_beat) << cur_size);
      r_data   = mem[a[13:2]];
      r_last   = rd_active && (rd_beat == rd_len);
      b_valid  = b_pend && (lfsr[6] | lfsr[7]);
      #1;
      ar_hs = ar_valid && ar_ready;
      r_hs  = r_valid && r_ready;
      aw_hs = aw_valid && aw_ready;
      w_hs  = w_valid && w_ready;
      b_hs  = b_valid && b_ready;
      r_was_last = r_last;
      w_was_last = w_last;
      if (ar_valid) chk("R3", "aw/w valid during ar", {30'd0, aw_valid, w_valid}, 32'd0);
      if (ar_hs) begin
        ar_cnt++;
        rd_addr = ar_addr;
        rd_len  = ar_len;
        if (exp_ar.size() == 0) chk(stop_mode ? "R9" : "R8", "unexpected AR", ar_addr, 32'hFFFFFFFF);
        else chk("R4", "ar_addr", ar_addr, exp_ar.pop_front());
        chk("R2", "ar_len", 32'(ar_len), 32'(cur_len));
        chk("R2", "ar_size", 32'(ar_size), 32'(cur_size));
        chk("R2", "ar_burst", 32'(ar_burst), 32'd1);
      end
      if (r_hs) sb_data.push_back(r_data);
      if (aw_hs) begin
        chk("R3", "aw before read end", {31'd0, rd_active}, 32'd0);
        if (exp_aw.size() == 0) chk("R4", "unexpected AW", aw_addr, 32'hFFFFFFFF);
        else chk("R4", "aw_addr", aw_addr, exp_aw.pop_front());
        chk("R4", "aw_len", 32'(aw_len), 32'(cur_len));
        wr_addr = aw_addr;
        wr_beat = 0;
      end
      if (w_hs) begin
        expd = (sb_data.size() != 0) ? sb_data.pop_front() : 32'hDEADBEEF;
        chk("R5", "w_data", w_data, expd);
        chk("R5", "w_strb", 32'(w_strb), 32'hF);
        chk("R5", "w_last", {31'd0, w_last}, {31'd0, wr_beat == cur_len});
        if (cur_size == 3'd2) begin
          a = wr_addr + (32'(wr_beat) << 2);
          mem[a[13:2]] = w_data;
        end
        wr_beat++;
      end
      if (b_hs) last_b_cyc = cyc;
      if (done_o) begin done_cnt++; done_cyc = cyc; end
    end
  end

  task automatic pulse_ctrl(input bit is_stop);
    @(negedge clk); #2;
    if (is_stop) stop_i = 1;
    else begin start_i = 1; src_i = 32'h3FF0; dst_i = 32'h3FF0; nbytes_i = 32'd4; len_i = 8'd0; end
    @(negedge clk); #2;
    start_i = 0; stop_i = 0;
  endtask

  // Driver: pushes expected addresses, starts a copy and checks completion.
  task automatic run_copy(input logic [31:0] src, input logic [31:0] dst, input logic [31:0] nb,
                          input logic [2:0] sz, input logic [7:0] ln, input int n_exp,
                          input int poke, input bit cmp, input string req);
    int bb, start_cyc, n;
    int bad;
    bb = (int'(ln) + 1) << sz;
    cur_size = sz; cur_len = ln; stop_mode = (poke == 2);
    for (int k = 0; k < n_exp; k++) begin
      exp_ar.push_back(src + 32'(k * bb));
      exp_aw.push_back(dst + 32'(k * bb));
    end
    done_cnt = 0; ar_cnt = 0;
    @(negedge clk); #2;
    start_i = 1; src_i = src; dst_i = dst; nbytes_i = nb; size_i = sz; len_i = ln;
    start_cyc = cyc;
    @(negedge clk); #2;
    start_i = 0;
    if (poke != 0) begin
      n = 0;
      while (ar_cnt == 0 && n < 20000) begin @(negedge clk); #2; n++; end
      pulse_ctrl(poke == 2);
    end
    n = 0;
    while (done_cnt == 0 && n < 20000) begin @(negedge clk); #2; n++; end
    repeat (6) @(negedge clk);
    #2;
    chk("R6", {req, " done pulse count"}, 32'(done_cnt), 32'd1);
    if (n_exp == 0) begin
      chk("R7", "done cycle after start", 32'(done_cyc), 32'(start_cyc + 1));
      chk("R7", "AR count", 32'(ar_cnt), 32'd0);
    end else begin
      chk("R6", {req, " done after last B"}, 32'(done_cyc), 32'(last_b_cyc + 1));
      chk("R4", {req, " burst count"}, 32'(ar_cnt), 32'(n_exp));
    end
    chk("R4", {req, " leftover AR"}, 32'(exp_ar.size()), 32'd0);
    chk("R4", {req, " leftover AW"}, 32'(exp_aw.size()), 32'd0);
    chk("R5", {req, " leftover beats"}, 32'(sb_data.size()), 32'd0);
    if (cmp) begin
      bad = 0;
      for (int i = 0; i < (n_exp * bb) / 4; i++)
        if (mem[(dst >> 2) + 32'(i)] !== mem[(src >> 2) + 32'(i)]) bad++;
      chk("R5", {req, " mismatched words"}, 32'(bad), 32'd0);
    end
    exp_ar.delete(); exp_aw.delete(); sb_data.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = (32'(i) * 32'h9E3779B1) ^ 32'h5A5A0F0F;
    repeat (3) @(negedge clk);
    #2;
    chk("R1", "outputs in reset", {26'd0, ar_valid, r_ready, aw_valid, w_valid, b_ready, done_o}, 32'd0);
    rst_n = 1;
    @(negedge clk); #2;
    chk("R1", "outputs after reset", {26'd0, ar_valid, r_ready, aw_valid, w_valid, b_ready, done_o}, 32'd0);
    run_copy(32'h0100, 32'h2100, 32'd64,   3'd2, 8'd3,   4, 0, 1, "R2");
    run_copy(32'h0800, 32'h2800, 32'd2048, 3'd2, 8'd255, 2, 0, 1, "R11");
    run_copy(32'h0040, 32'h3400, 32'd12,   3'd2, 8'd0,   3, 0, 1, "R4");
    run_copy(32'h1800, 32'h3800, 32'd32,   3'd1, 8'd7,   2, 0, 0, "R4");
    run_copy(32'h1000, 32'h3000, 32'd48,   3'd2, 8'd3,   3, 1, 1, "R8");
    run_copy(32'h1400, 32'h3C00, 32'd128,  3'd2, 8'd7,   1, 2, 1, "R9");
    run_copy(32'h0000, 32'h3E00, 32'd0,    3'd2, 8'd3,   0, 0, 0, "R7");
    summary();
    $finish;
  end
endmodule